// File: doc/BRIEF.md
# Four-Bit ALU Slice with Carry Lookahead

This block is a purely combinational arithmetic logic unit slice. It takes two operand words, a four-bit function code and a mode input, and produces a result word. With the mode input high it computes one of sixteen bitwise Boolean functions of the operands and the carry chain has no effect on the result. With the mode input low it computes one of sixteen arithmetic operations, each the sum of two words derived from the operands, plus an incoming carry.

Carries at the slice boundary are active-low. The slice also drives an active-low group propagate and an active-low group generate, so an external lookahead unit can form the carries of a wide word without rippling through every slice. An all-ones flag on the result serves as an equality detector when the slice subtracts, and the carry output then gives the relative magnitude of the operands. All data is active-high. Within the slice the carries come from a full lookahead over every bit position. The operand width is a parameter and defaults to four.

Top module: `alu_slice_top`

## Requirements
- R1: With `logicMode`=1, `result` is bitwise per `funcSel`: 0000 NOT A, 0001 NOT(A OR B), 0010 (NOT A) AND B, 0011 all zeros, 0100 NOT(A AND B), 0101 NOT B, 0110 A XOR B, 0111 A AND NOT B, 1000 (NOT A) OR B, 1001 NOT(A XOR B), 1010 B, 1011 A AND B, 1100 all ones, 1101 A OR NOT B, 1110 A OR B, 1111 A.
- R2: With `logicMode`=1, `carryInN` has no effect on `result`.
- R3: With `logicMode`=0, `result` is the low WIDTH bits of U + V + c, where c=1 when `carryInN`=0 and c=0 when `carryInN`=1. Here "-1" stands for all ones and the pairs (U,V) per `funcSel` are: 0000 (A,0), 0001 (A|B,0), 0010 (A|~B,0), 0011 (0,-1), 0100 (A,A&~B), 0101 (A|B,A&~B), 0110 (A,~B), 0111 (A&~B,-1), 1000 (A,A&B), 1001 (A,B), 1010 (A|~B,A&B), 1011 (A&B,-1), 1100 (A,A), 1101 (A|B,A), 1110 (A|~B,A), 1111 (A,-1).
- R4: Code 0110 in arithmetic mode subtracts: A-B-1 with `carryInN`=1 and A-B with `carryInN`=0, modulo 2^WIDTH.
- R5: Code 1001 in arithmetic mode adds: A+B, plus one when `carryInN`=0.
- R6: Code 1100 in arithmetic mode doubles A, moving every bit one place toward the most significant end, with the carry entering at bit 0.
- R7: `carryOutN` is 0 exactly when U+V+c of R3 reaches 2^WIDTH. It follows the same rule in both modes.
- R8: `groupPropN` is 0 exactly when every bit of U OR V is 1, i.e. every position passes a carry on.
- R9: `groupGenN` is 0 exactly when U+V with no carry in reaches 2^WIDTH. `carryOutN` is 0 exactly when `groupGenN` is 0, or when `groupPropN` and `carryInN` are both 0.
- R10: `allOnes` is 1 exactly when every bit of `result` is 1.
- R11: In subtract mode (`logicMode`=0, code 0110) `carryOutN` gives magnitude. With `carryInN`=1, `carryOutN`=1 means A<=B and 0 means A>B. With `carryInN`=0, `carryOutN`=1 means A<B and 0 means A>=B.
- R12: In subtract mode with `carryInN`=1, `allOnes` is 1 exactly when A equals B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| funcSel | input | 4 | Function code |
| logicMode | input | 1 | 1 = bitwise functions, 0 = arithmetic |
| carryInN | input | 1 | Carry in, active-low |
| result | output | WIDTH | Function result |
| carryOutN | output | 1 | Carry out of the slice, active-low |
| groupPropN | output | 1 | Group propagate, active-low |
| groupGenN | output | 1 | Group generate, active-low |
| allOnes | output | 1 | High when every result bit is 1 |

## Verification
The bench builds the slice with the default WIDTH of four. Operands, function code, mode and carry then make up only 2^14 input combinations, so every one of them is applied and compared against reference functions written from the requirement tables. That sweep covers every carry-chain pattern through the lookahead, including the propagate-only case in which a carry in passes through all four bits. A seeded random pass and directed cases follow, aimed at magnitude, equality and carry-independence in logic mode.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  localparam int SEL_W = 4;

  localparam logic [SEL_W-1:0] OP_SUB   = 4'b0110;
  localparam logic [SEL_W-1:0] OP_ADD   = 4'b1001;
  localparam logic [SEL_W-1:0] OP_XOR_L = 4'b0110;

  // Enables for the two per-bit operand terms and the logic-mode carry override.
  typedef struct packed {
    logic xTakeB;      // upper term includes A&B-side of B
    logic xTakeNotB;   // upper term includes ~B
    logic yTakeANotB;  // lower term includes A&~B
    logic yTakeAB;     // lower term includes A&B
    logic carryKill;   // logic mode: chain replaced by a constant
  } sliceCtl_t;

endpackage

// File: rtl/alu_slice_ctrl.sv
module alu_slice_ctrl
  import alu_slice_pkg::*;
(
  input  logic [SEL_W-1:0] funcSel,
  input  logic             logicMode,
  output sliceCtl_t        ctl
);

  // Each code bit steers one product term; the mode bit overrides the chain.
  always_comb begin
    ctl.xTakeB     = funcSel[0];
    ctl.xTakeNotB  = funcSel[1];
    ctl.yTakeANotB = funcSel[2];
    ctl.yTakeAB    = funcSel[3];
    ctl.carryKill  = logicMode;
  end

endmodule

// File: rtl/alu_slice_cla.sv
module alu_slice_cla #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] gen,
  input  logic             carryIn,
  output logic [WIDTH:0]   carry,
  output logic             groupProp,
  output logic             groupGen
);

  // Sum-of-products carry into position top+1: no term depends on another carry.
  function automatic logic reachCarry(input logic [WIDTH-1:0] p,
                                      input logic [WIDTH-1:0] g,
                                      input logic             c0,
                                      input int               top);
    logic acc;
    logic chain;
    acc = c0;
    for (int j = 0; j <= top; j++) acc = acc & p[j];
    for (int j = 0; j <= top; j++) begin
      chain = g[j];
      for (int k = j + 1; k <= top; k++) chain = chain & p[k];
      acc = acc | chain;
    end
    return acc;
  endfunction

  assign carry[0] = carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : gCarry
    assign carry[i+1] = reachCarry(prop, gen, carryIn, i);
  end

  assign groupProp = &prop;
  assign groupGen  = reachCarry(prop, gen, 1'b0, WIDTH - 1);

endmodule

// File: rtl/alu_slice_dp.sv
module alu_slice_dp
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  sliceCtl_t        ctl,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             groupProp,
  output logic             groupGen
);

  logic [WIDTH-1:0] upperTerm;
  logic [WIDTH-1:0] lowerTerm;
  logic [WIDTH:0]   carry;

  // lowerTerm always implies upperTerm, so upper acts as propagate and lower as generate.
  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    assign upperTerm[i] = opA[i]
                        | (opB[i] & ctl.xTakeB)
                        | (~opB[i] & ctl.xTakeNotB);
    assign lowerTerm[i] = (opA[i] & opB[i] & ctl.yTakeAB)
                        | (opA[i] & ~opB[i] & ctl.yTakeANotB);
    assign result[i]    = upperTerm[i] ^ lowerTerm[i] ^ (ctl.carryKill | carry[i]);
  end

  alu_slice_cla #(.WIDTH(WIDTH)) cla_i (
    .prop     (upperTerm),
    .gen      (lowerTerm),
    .carryIn  (carryIn),
    .carry    (carry),
    .groupProp(groupProp),
    .groupGen (groupGen)
  );

  assign carryOut = carry[WIDTH];

endmodule

// File: rtl/alu_slice_top.sv
module alu_slice_top
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SEL_W-1:0] funcSel,
  input  logic             logicMode,
  input  logic             carryInN,
  output logic [WIDTH-1:0] result,
  output logic             carryOutN,
  output logic             groupPropN,
  output logic             groupGenN,
  output logic             allOnes
);

  sliceCtl_t ctl;
  logic      carryOutHi;
  logic      groupPropHi;
  logic      groupGenHi;

  alu_slice_ctrl ctrl_i (
    .funcSel  (funcSel),
    .logicMode(logicMode),
    .ctl      (ctl)
  );

  alu_slice_dp #(.WIDTH(WIDTH)) dp_i (
    .opA      (opA),
    .opB      (opB),
    .ctl      (ctl),
    .carryIn  (~carryInN),
    .result   (result),
    .carryOut (carryOutHi),
    .groupProp(groupPropHi),
    .groupGen (groupGenHi)
  );

  assign carryOutN  = ~carryOutHi;
  assign groupPropN = ~groupPropHi;
  assign groupGenN  = ~groupGenHi;
  assign allOnes    = &result;

endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [SEL_W-1:0] funcSel,
  input logic             logicMode,
  input logic             carryInN,
  input logic [WIDTH-1:0] result,
  input logic             carryOutN,
  input logic             groupPropN,
  input logic             groupGenN,
  input logic             allOnes
);

  logic known;
  assign known = !$isunknown({opA, opB, funcSel, logicMode, carryInN});

  always_comb begin
    if (known && logicMode && funcSel == OP_XOR_L) begin
      AST_LOGIC_XOR: assert (result == (opA ^ opB)) else $error("logic xor mismatch"); // R1
    end
    if (known && !logicMode && funcSel == OP_ADD) begin
      AST_ADD_SUM: assert ({~carryOutN, result} ==
                           ((WIDTH+1)'(opA) + (WIDTH+1)'(opB) + (WIDTH+1)'(!carryInN)))
        else $error("add mismatch"); // R5
    end
    if (known) begin
      AST_CARRY_FROM_GROUP: assert (carryOutN == !(!groupGenN || (!groupPropN && !carryInN)))
        else $error("carry out disagrees with group terms"); // R9
    end
    if (known && !logicMode && funcSel == OP_SUB && carryInN) begin
      AST_SUB_MAGNITUDE: assert (carryOutN == !(opA > opB)) else $error("magnitude mismatch"); // R11
      AST_SUB_EQUAL: assert (allOnes == (opA == opB)) else $error("equality mismatch"); // R12
    end
  end

endmodule

bind alu_slice_top alu_slice_chk #(.WIDTH(WIDTH)) chk_i (
  .opA       (opA),
  .opB       (opB),
  .funcSel   (funcSel),
  .logicMode (logicMode),
  .carryInN  (carryInN),
  .result    (result),
  .carryOutN (carryOutN),
  .groupPropN(groupPropN),
  .groupGenN (groupGenN),
  .allOnes   (allOnes)
);

// File: tb/alu_slice_top_tb_top.sv
module alu_slice_top_tb_top;

  localparam int W    = 4;
  localparam int SPAN = 1 << W;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [3:0]   funcSel = '0;
  logic         logicMode = 1'b0;
  logic         carryInN = 1'b1;
  logic [W-1:0] result;
  logic         carryOutN;
  logic         groupPropN;
  logic         groupGenN;
  logic         allOnes;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  alu_slice_top #(.WIDTH(W)) dut_i (
    .opA(opA), .opB(opB), .funcSel(funcSel), .logicMode(logicMode),
    .carryInN(carryInN), .result(result), .carryOutN(carryOutN),
    .groupPropN(groupPropN), .groupGenN(groupGenN), .allOnes(allOnes)
  );

  // R1 table
  function automatic logic [W-1:0] refLogic(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] s);
    case (s)
      4'b0000: return ~a;
      4'b0001: return ~(a | b);
      4'b0010: return ~a & b;
      4'b0011: return '0;
      4'b0100: return ~(a & b);
      4'b0101: return ~b;
      4'b0110: return a ^ b;
      4'b0111: return a & ~b;
      4'b1000: return ~a | b;
      4'b1001: return ~(a ^ b);
      4'b1010: return b;
      4'b1011: return a & b;
      4'b1100: return ONES;
      4'b1101: return a | ~b;
      4'b1110: return a | b;
      default: return a;
    endcase
  endfunction

  // R3 table: returns {U, V}
  function automatic logic [2*W-1:0] refPair(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] s);
    case (s)
      4'b0000: return {a, {W{1'b0}}};
      4'b0001: return {a | b, {W{1'b0}}};
      4'b0010: return {a | ~b, {W{1'b0}}};
      4'b0011: return {{W{1'b0}}, ONES};
      4'b0100: return {a, a & ~b};
      4'b0101: return {a | b, a & ~b};
      4'b0110: return {a, ~b};
      4'b0111: return {a & ~b, ONES};
      4'b1000: return {a, a & b};
      4'b1001: return {a, b};
      4'b1010: return {a | ~b, a & b};
      4'b1011: return {a & b, ONES};
      4'b1100: return {a, a};
      4'b1101: return {a | b, a};
      4'b1110: return {a | ~b, a};
      default: return {a, ONES};
    endcase
  endfunction

  task automatic checkVal(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h (a=%0h b=%0h s=%b m=%b cn=%b)",
               tag, what, act, exp, opA, opB, funcSel, logicMode, carryInN);
    end
  endtask

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] s, logic m, logic cn);
    @(posedge clk);
    opA = a; opB = b; funcSel = s; logicMode = m; carryInN = cn;
    @(negedge clk);
  endtask

  // Full comparison of every output against the reference tables.
  task automatic applyFull(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] s, logic m, logic cn);
    logic [2*W-1:0] pair;
    logic [W-1:0]   u, v, expF;
    logic [W:0]     sumC, sumNoC;
    string          fTag;
    drive(a, b, s, m, cn);
    pair   = refPair(a, b, s);
    u      = pair[2*W-1:W];
    v      = pair[W-1:0];
    sumC   = {1'b0, u} + {1'b0, v} + {{W{1'b0}}, !cn};
    sumNoC = {1'b0, u} + {1'b0, v};
    if (m) begin
      expF = refLogic(a, b, s);
      fTag = "R1";
    end else begin
      expF = sumC[W-1:0];
      case (s)
        4'b0110: fTag = "R4";
        4'b1001: fTag = "R5";
        4'b1100: fTag = "R6";
        default: fTag = "R3";
      endcase
    end
    checkVal(fTag, "result", int'(result), int'(expF));
    checkVal("R7", "carryOutN", int'(carryOutN), int'(!sumC[W]));
    checkVal("R8", "groupPropN", int'(groupPropN), int'((u | v) != ONES));
    checkVal("R9", "groupGenN", int'(groupGenN), int'(!sumNoC[W]));
    checkVal("R10", "allOnes", int'(allOnes), int'(expF == ONES));
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd20240611);

    // Idle state: all-zero operands, code 0000, arithmetic, no carry -> A passes, no carry out.
    @(negedge clk);
    checkVal("R3", "idle result", int'(result), 0);
    checkVal("R7", "idle carryOutN", int'(carryOutN), 1);

    // Exhaustive sweep over operands, code, mode and carry.
    for (int vec = 0; vec < (1 << (2 * W + 6)); vec++) begin
      applyFull(W'(vec), W'(vec >> W), 4'(vec >> (2 * W)),
                vec[2 * W + 4], vec[2 * W + 5]);
    end

    // Seeded random pass.
    for (int k = 0; k < 2000; k++) begin
      applyFull(W'($urandom), W'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
    end

    // R2: logic result unchanged when only the carry input flips.
    for (int s = 0; s < 16; s++) begin
      logic [W-1:0] a, b, fNoCarry;
      a = W'($urandom); b = W'($urandom);
      drive(a, b, 4'(s), 1'b1, 1'b1);
      fNoCarry = result;
      drive(a, b, 4'(s), 1'b1, 1'b0);
      checkVal("R2", "logic result vs carry", int'(result), int'(fNoCarry));
    end

    // R4 directed: 9-3.
    drive(4'd9, 4'd3, 4'b0110, 1'b0, 1'b1);
    checkVal("R4", "9-3-1", int'(result), 5);
    drive(4'd9, 4'd3, 4'b0110, 1'b0, 1'b0);
    checkVal("R4", "9-3", int'(result), 6);
    // R5 directed: 9+8 overflows.
    drive(4'd9, 4'd8, 4'b1001, 1'b0, 1'b1);
    checkVal("R5", "9+8 result", int'(result), 1);
    checkVal("R5", "9+8 carryOutN", int'(carryOutN), 0);
    // R6 directed: shift.
    drive(4'b0101, 4'd0, 4'b1100, 1'b0, 1'b1);
    checkVal("R6", "shift 0101", int'(result), 4'b1010);
    drive(4'b1011, 4'd7, 4'b1100, 1'b0, 1'b0);
    checkVal("R6", "shift 1011 +1 result", int'(result), 4'b0111);
    checkVal("R6", "shift 1011 +1 carryOutN", int'(carryOutN), 0);

    // R11 / R12: all operand pairs in subtract mode.
    for (int a = 0; a < SPAN; a++) begin
      for (int b = 0; b < SPAN; b++) begin
        drive(W'(a), W'(b), 4'b0110, 1'b0, 1'b1);
        checkVal("R11", "magnitude cn=1", int'(carryOutN), int'(a <= b));
        checkVal("R12", "equality", int'(allOnes), int'(a == b));
        drive(W'(a), W'(b), 4'b0110, 1'b0, 1'b0);
        checkVal("R11", "magnitude cn=0", int'(carryOutN), int'(a < b));
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL R1..all watchdog: actual %0d cycles expected completion earlier", 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule